// File: doc/BRIEF.md
# Vectored Interrupt Receiver

This block collects level-sensitive interrupt requests from peripherals and turns them into one vectored interrupt for the processor. Each of the `NUM_VEC` vector lines stands for one interrupt number. When a line is high and the receiver is idle, the receiver captures that number into three data words. It raises a request with a fixed trap type and stays busy until the captured line falls. While busy, it takes no new vector.

A routing stage folds a 16-line legacy ISA interrupt bus into the vector space. Only five ISA lines have a vector assigned; the other eleven are dropped. When several lines are high in the same cycle, the lowest vector number wins. All outputs come from registers and change one clock edge after the input that causes them.

Top module: `ivr_top`

## Requirements
- R1: After reset, `busy_o` and `req_o` are 0, `trap_type_o` is 0 and all three data words are 0.
- R2: When the receiver is idle and any effective line is high, on the next edge `busy_o` and `req_o` go to 1 and `trap_type_o` becomes 9'h060.
- R3: On acceptance, data word 0 holds 64'h7C0 OR the vector number: bits 10:6 are all ones, bits 5:0 hold the vector and all higher bits are zero. Data words 1 and 2 are set to zero.
- R4: While busy, newly asserted lines are ignored. The three data words keep their values and `busy_o` stays 1 as long as the captured line stays high.
- R5: When the captured line is low while busy, on the next edge `busy_o` and `req_o` go to 0 and `trap_type_o` goes to 0. The data words keep their last values. A line that is still high is accepted one edge later.
- R6: ISA routing is as follows: ISA line 1 drives vector 0x29, line 4 drives 0x2B, line 6 drives 0x27, line 7 drives 0x22 and line 12 drives 0x2A. An ISA line and its routed vector line are ORed together.
- R7: ISA lines 0, 2, 3, 5, 8 to 11 and 13 to 15 have no effect: on their own they leave `busy_o` and `req_o` at 0.
- R8: When several effective lines are high in the same cycle while idle, the lowest vector number is accepted.
- R9: Every vector number from 0x00 to 0x3F can be accepted and appears in data word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_lines_i | input | 64 | Level interrupt lines, one per vector number |
| isa_lines_i | input | 16 | Legacy ISA interrupt lines |
| busy_o | output | 1 | A vector is captured and not yet released |
| req_o | output | 1 | Interrupt request to the processor |
| trap_type_o | output | 9 | Trap type: 0x060 while a request is raised, 0 otherwise |
| data0_o | output | 64 | Marker 0x1F at bits 10:6 ORed with the captured vector number |
| data1_o | output | 64 | Cleared on acceptance |
| data2_o | output | 64 | Cleared on acceptance |

## Verification
A wrong captured vector number appears in data word 0 on the edge after acceptance. It also shows up later as a release that happens at the wrong time, because release follows the captured line. A busy flag that sticks or clears too early shows up within one cycle: `req_o` stays high after the source falls, or a second vector overwrites the data words. A routing or priority fault appears as the wrong vector number, or as no request at all, on the first edge after the lines are driven.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int unsigned ISA_LINES = 16;
    localparam int unsigned TT_W      = 9;
    localparam logic [TT_W-1:0] TT_VECTORED = 9'h060;
    localparam int unsigned MARK_SHIFT = 6;
    localparam logic [4:0]  MARK_BITS  = 5'h1F;

    typedef struct packed {
        logic       valid;
        logic [5:0] vec;
    } isa_route_t;

    // Fixed sparse routing of ISA lines onto vector numbers
    function automatic isa_route_t isa_route(input int unsigned line);
        isa_route_t r;
        r.valid = 1'b1;
        case (line)
            1:       r.vec = 6'h29;
            4:       r.vec = 6'h2B;
            6:       r.vec = 6'h27;
            7:       r.vec = 6'h22;
            12:      r.vec = 6'h2A;
            default: begin r.valid = 1'b0; r.vec = 6'h00; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ivr_isa_route.sv
module ivr_isa_route
    import ivr_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ISA_LINES-1:0] isa_i,
    output logic [NUM_VEC-1:0]   vec_o
);
    logic [NUM_VEC-1:0] part [ISA_LINES];

    for (genvar g = 0; g < ISA_LINES; g++) begin : g_line
        localparam isa_route_t RT = isa_route(g);
        if (RT.valid && (int'(RT.vec) < NUM_VEC)) begin : g_routed
            always_comb begin
                part[g] = '0;
                part[g][RT.vec] = isa_i[g];
            end
        end else begin : g_dropped
            assign part[g] = '0;
        end
    end

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < ISA_LINES; i++) vec_o = vec_o | part[i];
    end

    AST_ISA_LINE1_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        isa_i[1] |-> vec_o[6'h29]);  // R6
    AST_ISA_LINE12_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        isa_i[12] |-> vec_o[6'h2A]); // R6
endmodule

// File: rtl/ivr_prio_pick.sv
module ivr_prio_pick #(
    parameter int unsigned N  = 64,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  lines_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        valid_o = |lines_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lines_i[i]) idx_o = IW'(i);
        end
    end

    logic [N-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < N; i++) below_mask[i] = (IW'(i) < idx_o);
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (lines_i[idx_o] && ((lines_i & below_mask) == '0))); // R8
endmodule

// File: rtl/ivr_core.sv
module ivr_core
    import ivr_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned DATA_W  = 64,
    localparam int unsigned IW = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] lines_i,
    input  logic               pick_valid_i,
    input  logic [IW-1:0]      pick_idx_i,
    output logic               busy_o,
    output logic               req_o,
    output logic [TT_W-1:0]    tt_o,
    output logic [DATA_W-1:0]  data0_o,
    output logic [DATA_W-1:0]  data1_o,
    output logic [DATA_W-1:0]  data2_o
);
    typedef struct packed {
        logic              busy;
        logic              req;
        logic [IW-1:0]     held;
        logic [TT_W-1:0]   tt;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
        logic [DATA_W-1:0] d2;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (pick_valid_i) begin
                st_d.busy = 1'b1;
                st_d.req  = 1'b1;
                st_d.held = pick_idx_i;
                st_d.tt   = TT_VECTORED;
                st_d.d0   = DATA_W'({MARK_BITS, 6'(pick_idx_i)});
                st_d.d1   = '0;
                st_d.d2   = '0;
            end
        end else if (!lines_i[st_q.held]) begin
            st_d.busy = 1'b0;
            st_d.req  = 1'b0;
            st_d.tt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign req_o   = st_q.req;
    assign tt_o    = st_q.tt;
    assign data0_o = st_q.d0;
    assign data1_o = st_q.d1;
    assign data2_o = st_q.d2;

    AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && (|lines_i)) |=> (st_q.busy && st_q.req && st_q.tt == TT_VECTORED)); // R2
    AST_DATA_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> (st_q.d0[MARK_SHIFT+4:MARK_SHIFT] == MARK_BITS
                              && st_q.d1 == '0 && st_q.d2 == '0));          // R3
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && lines_i[st_q.held]) |=> (st_q.busy && $stable(st_q.d0)
                                               && $stable(st_q.held)));    // R4
    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !lines_i[st_q.held]) |=> (!st_q.busy && !st_q.req
                                                && $stable(st_q.d0)));     // R5
endmodule

// File: rtl/ivr_top.sv
module ivr_top
    import ivr_pkg::*;
#(
    parameter int unsigned NUM_VEC = 64,
    parameter int unsigned DATA_W  = 64,
    localparam int unsigned IW = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VEC-1:0]   vec_lines_i,
    input  logic [ISA_LINES-1:0] isa_lines_i,
    output logic                 busy_o,
    output logic                 req_o,
    output logic [TT_W-1:0]      trap_type_o,
    output logic [DATA_W-1:0]    data0_o,
    output logic [DATA_W-1:0]    data1_o,
    output logic [DATA_W-1:0]    data2_o
);
    logic [NUM_VEC-1:0] isa_vec;
    logic [NUM_VEC-1:0] eff_lines;
    logic               pick_valid;
    logic [IW-1:0]      pick_idx;

    ivr_isa_route #(.NUM_VEC(NUM_VEC)) u_route (
        .clk(clk), .rst_n(rst_n), .isa_i(isa_lines_i), .vec_o(isa_vec)
    );

    assign eff_lines = vec_lines_i | isa_vec;

    ivr_prio_pick #(.N(NUM_VEC)) u_pick (
        .clk(clk), .rst_n(rst_n), .lines_i(eff_lines),
        .valid_o(pick_valid), .idx_o(pick_idx)
    );

    ivr_core #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .lines_i(eff_lines),
        .pick_valid_i(pick_valid), .pick_idx_i(pick_idx),
        .busy_o(busy_o), .req_o(req_o), .tt_o(trap_type_o),
        .data0_o(data0_o), .data1_o(data1_o), .data2_o(data2_o)
    );
endmodule

// File: tb/ivr_top_tb.sv
module ivr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] vec = '0;
    logic [15:0] isa = '0;
    logic        busy, req;
    logic [8:0]  tt;
    logic [63:0] d0, d1, d2;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ivr_top u_dut (
        .clk(clk), .rst_n(rst_n), .vec_lines_i(vec), .isa_lines_i(isa),
        .busy_o(busy), .req_o(req), .trap_type_o(tt),
        .data0_o(d0), .data1_o(d1), .data2_o(d2)
    );

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] d0_of(input int v);
        return 64'h7C0 | 64'(v);
    endfunction

    function automatic int isa_vec_of(input int line);
        case (line)
            1: return 'h29;
            4: return 'h2B;
            6: return 'h27;
            7: return 'h22;
            12: return 'h2A;
            default: return -1;
        endcase
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drive(input logic [63:0] v, input logic [15:0] s);
        @(negedge clk); vec = v; isa = s;
    endtask

    task automatic accepted(input string rq, input int v);
        chk(rq, "busy", 64'(busy), 64'd1);
        chk(rq, "req", 64'(req), 64'd1);
        chk(rq, "trap", 64'(tt), 64'h60);
        chk(rq, "data0", d0, d0_of(v));
        chk(rq, "data1", d1, 64'd0);
        chk(rq, "data2", d2, 64'd0);
    endtask

    task automatic idle_now(input string rq);
        chk(rq, "busy", 64'(busy), 64'd0);
        chk(rq, "req", 64'(req), 64'd0);
        chk(rq, "trap", 64'(tt), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        idle_now("R1");
        chk("R1", "data0", d0, 64'd0);
        chk("R1", "data1", d1, 64'd0);
        chk("R1", "data2", d2, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        step();
        idle_now("R1");

        // R9 / R2 / R3 / R4 / R5: sweep every vector
        for (int v = 0; v < 64; v++) begin
            drive(64'd1 << v, '0);
            step();
            accepted("R9", v);
            // R4: extra lines while busy are ignored
            drive((64'd1 << v) | ~(64'd1 << v), 16'hFFFF);
            step();
            chk("R4", "busy", 64'(busy), 64'd1);
            chk("R4", "data0", d0, d0_of(v));
            // R5: drop everything, release
            drive('0, '0);
            step();
            idle_now("R5");
            chk("R5", "data0 kept", d0, d0_of(v));
        end

        // R6 / R7: every ISA line alone
        for (int l = 0; l < 16; l++) begin
            drive('0, 16'd1 << l);
            step();
            if (isa_vec_of(l) >= 0) accepted("R6", isa_vec_of(l));
            else idle_now("R7");
            drive('0, '0);
            step();
            idle_now(isa_vec_of(l) >= 0 ? "R6" : "R7");
        end

        // R8: pairs; lower wins, higher taken after release (R5)
        for (int i = 0; i < 63; i += 3) begin
            int j;
            j = 63 - (i / 3);
            if (j <= i) j = i + 1;
            drive((64'd1 << i) | (64'd1 << j), '0);
            step();
            accepted("R8", i);
            drive(64'd1 << j, '0);
            step();
            idle_now("R5");
            step();
            accepted("R5", j);
            drive('0, '0);
            step();
            idle_now("R5");
        end

        // R8 with ISA vs direct: ISA line 7 -> 0x22 beats direct 0x30
        drive(64'd1 << 'h30, 16'd1 << 7);
        step();
        accepted("R8", 'h22);
        // R6: release follows routed ISA line
        drive(64'd1 << 'h30, '0);
        step();
        idle_now("R6");
        step();
        accepted("R8", 'h30);
        drive('0, '0);
        step();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule